// File: doc/BRIEF.md
# Two-Step Subranging Conversion Sequencer

This block sequences an 8-bit two-pass analog-to-digital conversion in which one bank of 15 comparators is used twice. First the comparators hold the input with offset cancellation, then they are compared against the 15 boundaries between the 16 rows of a resistor ladder to find the upper nibble. Finally they are compared against the 15 taps inside the single row that the upper nibble names, which gives the lower nibble.

The comparator bank's thermometer output is assumed to be encoded to 4 bits outside this block. The sequencer reads that code twice per conversion. After the first read it steers the ladder row switches, and after the second it completes the result word and pulses a done flag. With start held high, conversions run back to back with a period of four clocks.

The reset is asynchronous and active-low. Its release passes through a two-stage synchronizer, so the sequencer leaves reset two clock edges after `rst_n` rises.

Top module: `subrange_seq`

## Requirements
- R1: While in reset, and after it, until the first start: `smp_en`=1, `cmp_en`=0, `coarse_taps`=0, `ladder_row`=0, `conv_data`=0, `conv_done`=0.
- R2: A start seen in the sample state runs four phases, one clock each and in this order: gap, coarse, fine, then sample again. Start is looked at only in the sample state.
- R3: `smp_en` and `cmp_en` are never high together. In the gap cycle that follows sampling, both are low.
- R4: In the coarse cycle `cmp_en`=1 and `coarse_taps`=1, and `ladder_row` is all zeros.
- R5: At the end of the coarse cycle the code is written to `conv_data[7:4]`, and that same code selects the row used for the fine pass.
- R6: In the fine cycle `coarse_taps`=0 and exactly one `ladder_row` bit is set, the one at the index equal to `conv_data[7:4]`. Outside the fine cycle `ladder_row` is zero. `coarse_taps` is low whenever `smp_en` is high.
- R7: At the end of the fine cycle the code is written to `conv_data[3:0]`. In the next cycle `conv_done` is high for exactly one clock and `smp_en` is high again.
- R8: `conv_data` holds its value between conversions. A new conversion first changes only bits [7:4], at the end of its coarse cycle.
- R9: While start stays high, a new conversion begins immediately after each one ends, giving one result every 4 clocks.
- R10: While start is low in the sample state, the sequencer stays there with `smp_en`=1 and `cmp_en`=0, and `conv_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a conversion; held high it repeats conversions |
| cmp_code | input | 4 | Encoded comparator bank result |
| smp_en | output | 1 | Comparator sample / offset-cancel switch enable |
| cmp_en | output | 1 | Comparator compare switch enable |
| coarse_taps | output | 1 | Connect the comparators to the inter-row ladder taps |
| ladder_row | output | 16 | One-hot row connect for the fine pass |
| conv_data | output | 8 | Result word |
| conv_done | output | 1 | One-clock end-of-conversion pulse |

## Verification
The assertions assume that `cmp_code` is a known 4-bit value at every clock edge, and that `start` and `rst_n` change only away from the rising edge. The bench meets this with a behavioural comparator and ladder model that always drives a defined code. In the coarse phase the model returns the upper nibble of the analog value. In the fine phase it returns 0 or 15 when the selected row lies above or below the input, and the lower nibble when the row matches. All inputs change on the falling clock edge.

// File: rtl/subrange_pkg.sv
package subrange_pkg;
  typedef enum logic [1:0] {
    PH_SAMPLE = 2'd0,
    PH_GAP    = 2'd1,
    PH_COARSE = 2'd2,
    PH_FINE   = 2'd3
  } phase_t;
endpackage

// File: rtl/sr_rst_sync.sv
module sr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= {pipe_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = pipe_q[STAGES-1];
endmodule

// File: rtl/sr_phase_fsm.sv
module sr_phase_fsm
  import subrange_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  output phase_t phase,
  output logic   load_hi,
  output logic   load_lo,
  output logic   done
);
  phase_t phase_q, phase_d;
  logic   done_q;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    unique case (phase_q)
      PH_SAMPLE: if (start) phase_d = PH_GAP;
      PH_GAP:    phase_d = PH_COARSE;
      PH_COARSE: phase_d = PH_FINE;
      PH_FINE:   phase_d = PH_SAMPLE;
      default:   phase_d = PH_SAMPLE;
    endcase
  end

  assign load_hi = (phase_q == PH_COARSE);
  assign load_lo = (phase_q == PH_FINE);

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_SAMPLE;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      done_q  <= load_lo;
    end
  end

  assign phase = phase_q;
  assign done  = done_q;
endmodule

// File: rtl/sr_result_regs.sv
module sr_result_regs #(
  parameter int CODE_W = 4,
  localparam int DATA_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_hi,
  input  logic              load_lo,
  input  logic [CODE_W-1:0] code,
  output logic [DATA_W-1:0] data,
  output logic [CODE_W-1:0] row_idx
);
  logic [CODE_W-1:0] hi_q, lo_q;

  // upper nibble: clock-enabled by the coarse phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hi_q <= '0;
    else if (load_hi) hi_q <= code;
  end

  // lower nibble: clock-enabled by the fine phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lo_q <= '0;
    else if (load_lo) lo_q <= code;
  end

  assign data    = {hi_q, lo_q};
  assign row_idx = hi_q;
endmodule

// File: rtl/sr_row_decode.sv
module sr_row_decode #(
  parameter int CODE_W = 4,
  localparam int ROWS = 1 << CODE_W
) (
  input  logic              en,
  input  logic [CODE_W-1:0] idx,
  output logic [ROWS-1:0]   rows
);
  for (genvar g = 0; g < ROWS; g++) begin : g_row
    assign rows[g] = en && (idx == CODE_W'(g));
  end
endmodule

// File: rtl/subrange_seq.sv
module subrange_seq
  import subrange_pkg::*;
#(
  parameter int CODE_W     = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ROWS   = 1 << CODE_W,
  localparam int DATA_W = 2 * CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CODE_W-1:0] cmp_code,
  output logic              smp_en,
  output logic              cmp_en,
  output logic              coarse_taps,
  output logic [ROWS-1:0]   ladder_row,
  output logic [DATA_W-1:0] conv_data,
  output logic              conv_done
);
  logic              rst_n_int;
  phase_t            phase;
  logic              load_hi, load_lo;
  logic [CODE_W-1:0] row_idx;

  sr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_int)
  );

  sr_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n_int), .start(start), .phase(phase),
    .load_hi(load_hi), .load_lo(load_lo), .done(conv_done)
  );

  sr_result_regs #(.CODE_W(CODE_W)) u_res (
    .clk(clk), .rst_n(rst_n_int), .load_hi(load_hi), .load_lo(load_lo),
    .code(cmp_code), .data(conv_data), .row_idx(row_idx)
  );

  sr_row_decode #(.CODE_W(CODE_W)) u_dec (
    .en(phase == PH_FINE), .idx(row_idx), .rows(ladder_row)
  );

  assign smp_en      = (phase == PH_SAMPLE);
  assign cmp_en      = (phase == PH_COARSE) || (phase == PH_FINE);
  assign coarse_taps = (phase == PH_COARSE);
endmodule

// File: rtl/subrange_seq_chk.sv
module subrange_seq_chk #(
  parameter int CODE_W = 4,
  localparam int ROWS   = 1 << CODE_W,
  localparam int DATA_W = 2 * CODE_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CODE_W-1:0] cmp_code,
  input logic              smp_en,
  input logic              cmp_en,
  input logic              coarse_taps,
  input logic [ROWS-1:0]   ladder_row,
  input logic [DATA_W-1:0] conv_data,
  input logic              conv_done
);
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(smp_en && cmp_en)); // R3
  AST_GAP_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(smp_en) |-> !cmp_en); // R3
  AST_COARSE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_taps |-> (cmp_en && ladder_row == '0)); // R4
  AST_COARSE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_taps |=> conv_data[DATA_W-1:CODE_W] == $past(cmp_code)); // R5
  AST_FINE_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    coarse_taps |=> ladder_row == ({{(ROWS-1){1'b0}}, 1'b1} << $past(cmp_code))); // R5
  AST_ROW_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ladder_row)); // R6
  AST_SAMPLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    smp_en |-> (!coarse_taps && ladder_row == '0)); // R6
  AST_FINE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ladder_row != '0) |=> (conv_done && smp_en && conv_data[CODE_W-1:0] == $past(cmp_code))); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    conv_done |=> !conv_done); // R7
endmodule

bind subrange_seq subrange_seq_chk #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_code(cmp_code), .smp_en(smp_en),
  .cmp_en(cmp_en), .coarse_taps(coarse_taps), .ladder_row(ladder_row),
  .conv_data(conv_data), .conv_done(conv_done)
);

// File: tb/test_subrange_seq.sv
module test_subrange_seq;
  localparam int CW = 4;
  localparam int NR = 1 << CW;
  localparam int DW = 2 * CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start;
  logic [CW-1:0] cmp_code;
  logic          smp_en, cmp_en, coarse_taps, conv_done;
  logic [NR-1:0] ladder_row;
  logic [DW-1:0] conv_data;

  logic [DW-1:0] vin;      // analog input, in LSBs
  logic [DW-1:0] last_val; // expected held result
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  subrange_seq i_subrange_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .cmp_code(cmp_code),
    .smp_en(smp_en), .cmp_en(cmp_en), .coarse_taps(coarse_taps),
    .ladder_row(ladder_row), .conv_data(conv_data), .conv_done(conv_done)
  );

  // behavioural comparator bank + ladder + encoder
  logic [NR-1:0] match_row;
  assign match_row = {{(NR-1){1'b0}}, 1'b1} << vin[DW-1:CW];
  always_comb begin
    if (coarse_taps)             cmp_code = vin[DW-1:CW];
    else if (ladder_row == '0)   cmp_code = '0;
    else if (ladder_row == match_row) cmp_code = vin[CW-1:0];
    else if (ladder_row > match_row)  cmp_code = '0;   // row above input
    else                         cmp_code = '1;        // row below input
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] ph();
    return {smp_en, cmp_en, coarse_taps};
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; vin = '0;
    repeat (3) @(negedge clk);
    chk("R1 phases in reset", 32'(ph()), 32'b100);
    chk("R1 rows in reset", 32'(ladder_row), 0);
    chk("R1 data in reset", 32'(conv_data), 0);
    chk("R1 done in reset", 32'(conv_done), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 phases after reset", 32'(ph()), 32'b100);
    chk("R1 data after reset", 32'(conv_data), 0);
    last_val = '0;
  endtask

  // one conversion, start pulsed for one clock
  task automatic t_single(input logic [DW-1:0] v);
    vin = v; start = 1'b1;
    @(negedge clk); start = 1'b0;
    chk("R3 gap phases", 32'(ph()), 32'b000);
    chk("R6 no row in gap", 32'(ladder_row), 0);
    @(negedge clk);
    chk("R4 coarse phases", 32'(ph()), 32'b011);
    chk("R4 no row in coarse", 32'(ladder_row), 0);
    chk("R8 data held into coarse", 32'(conv_data), 32'(last_val));
    @(negedge clk);
    chk("R6 fine phases", 32'(ph()), 32'b010);
    chk("R5 fine row from coarse code", 32'(ladder_row), 32'(match_row));
    chk("R8 only upper changed", 32'(conv_data), 32'({v[DW-1:CW], last_val[CW-1:0]}));
    @(negedge clk);
    chk("R7 done high", 32'(conv_done), 1);
    chk("R7 result", 32'(conv_data), 32'(v));
    chk("R2 back to sample", 32'(ph()), 32'b100);
    chk("R6 no row in sample", 32'(ladder_row), 0);
    last_val = v;
    @(negedge clk);
    chk("R7 done single pulse", 32'(conv_done), 0);
  endtask

  // no start: idles, result held
  task automatic t_idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      chk("R10 idle phases", 32'(ph()), 32'b100);
      chk("R10 no done when idle", 32'(conv_done), 0);
      chk("R8 data held idle", 32'(conv_data), 32'(last_val));
    end
  endtask

  // start held high over several conversions
  task automatic t_back_to_back();
    logic [DW-1:0] vals [4];
    vals[0] = 8'h3C; vals[1] = 8'hC3; vals[2] = 8'h10; vals[3] = 8'hEF;
    start = 1'b1;
    for (int k = 0; k < 4; k++) begin
      vin = vals[k];
      @(negedge clk);
      chk("R9 gap follows directly", 32'(ph()), 32'b000);
      chk("R9 no done in gap", 32'(conv_done), 0);
      @(negedge clk);
      chk("R2 coarse order", 32'(ph()), 32'b011);
      @(negedge clk);
      chk("R2 fine order", 32'(ph()), 32'b010);
      chk("R6 fine row", 32'(ladder_row), 32'(match_row));
      @(negedge clk);
      chk("R9 done every 4 clocks", 32'(conv_done), 1);
      chk("R9 result", 32'(conv_data), 32'(vals[k]));
      last_val = vals[k];
      if (k == 3) start = 1'b0;
    end
    @(negedge clk);
    chk("R10 stops when start low", 32'(ph()), 32'b100);
    chk("R7 done pulse ends", 32'(conv_done), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_idle(3);
    t_single(8'hA5);
    t_idle(5);
    t_single(8'h00);
    t_single(8'hFF);
    t_single(8'h5A);
    t_idle(2);
    t_back_to_back();
    t_single(8'h81);
    t_idle(3);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule